// File: doc/BRIEF.md
# Table-Programmed Two-Bit Mealy Controller

This block is a small synchronous state machine with two state bits, one data input and two outputs. It holds no gate-level next-state or output equations. Every decision comes from four one-bit-wide lookup tables of eight entries each. All four tables are indexed by the same 3-bit address, formed from the current state and the input. Two tables produce the next-state bits, which a register captures on the clock edge when the enable is high. The other two tables drive the outputs directly, so the outputs follow the input within the same cycle (Mealy behaviour).

Each table is an 8-bit parameter, so a different two-state-bit, one-input, two-output machine can be loaded without touching the logic. A build-time switch selects the storage arrangement. It can be four separate 8x1 tables, or one merged 8x4 table assembled from the same parameters. Both arrangements must behave the same.

Top module: `rom_mealy_fsm`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the state register becomes 00 at that edge.
- R2: The table address is {state[1], state[0], din}, where state[1] is the most significant bit. Bit n of each 8-bit table parameter is the value stored at address n.
- R3: With the default tables (next-state high bit 0x72, low bit 0x9E), an enabled edge moves the state as follows: 00 goes to 00 on din=0 and to 11 on din=1. 01 goes to 01 on either value. 10 goes to 11 on din=0 and to 10 on din=1. 11 goes to 10 on din=0 and to 01 on din=1.
- R4: With the default tables (output high bit 0x57, low bit 0xD8), dout is {OUT1,OUT0} for each state and din. State 00 gives 10 for both din values. State 01 gives 10 on din=0 and 01 on din=1. State 10 gives 11 on din=0 and 00 on din=1. State 11 gives 11 on din=0 and 01 on din=1.
- R5: dout is a combinational function of the current state and din. It reflects a change on din in the same cycle, with no clock edge in between.
- R6: When `en` is low and `rst` is low at a rising edge, the state does not change.
- R7: `rst` takes priority over `en`. A reset edge gives state 00 whatever `en` and `din` are.
- R8: Tables other than the defaults, loaded through the parameters, set both the transitions and the outputs by the bit-to-address rule of R2.
- R9: The merged 8x4 storage arrangement (`MERGED_ROM`=1) gives the same state sequence and outputs as the four-table arrangement for identical tables and stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the state to 00 |
| en | input | 1 | State-advance enable; the state holds when this is low |
| din | input | 1 | Machine input bit; the low bit of the table address |
| state_q | output | 2 | Current state register |
| dout | output | 2 | Mealy outputs {OUT1, OUT0} read from the output tables |

## Verification
The bench walks all eight state/input addresses and checks both the captured next state and the same-cycle outputs. A design that swapped the address bit order, or indexed the tables from the wrong end, would put outputs or transitions on the wrong address. State 01 is a trap under the default tables, so the bench has to leave it by reset. A reset that waited for `en` would leave the machine stuck there. The bench also holds `en` low and checks that the state stays put. It changes `din` in mid-cycle to catch outputs that were registered by mistake. Finally it runs a merged-storage instance and a non-default-table instance in lockstep, which exposes packing errors in the merged word and constants hard-wired in place of the parameters.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
    localparam int ST_W   = 2;
    localparam int IN_W   = 1;
    localparam int OUT_W  = 2;
    localparam int ADDR_W = ST_W + IN_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = ST_W + OUT_W;

    typedef logic [ST_W-1:0]   state_t;
    typedef logic [OUT_W-1:0]  out_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DEPTH-1:0]  table_t;

    typedef struct packed {
        state_t nxt;
        out_t   out;
    } rom_word_t;

    typedef rom_word_t [DEPTH-1:0] rom_image_t;
    typedef table_t [WORD_W-1:0]   table_set_t;

    function automatic addr_t make_addr(input state_t s, input logic d);
        return {s, d};
    endfunction

    function automatic rom_image_t build_image(input table_set_t tabs);
        rom_image_t img;
        for (int a = 0; a < DEPTH; a++) begin
            for (int k = 0; k < WORD_W; k++) begin
                img[a][k] = tabs[k][a];
            end
        end
        return img;
    endfunction
endpackage

// File: rtl/rmf_rom_bit.sv
module rmf_rom_bit
    import rmf_pkg::*;
#(
    parameter table_t CONTENT = '0
) (
    input  addr_t addr,
    output logic  data
);
    assign data = CONTENT[addr];
endmodule

// File: rtl/rmf_lookup.sv
module rmf_lookup
    import rmf_pkg::*;
#(
    parameter table_set_t TABLES     = '0,
    parameter bit         MERGED_ROM = 1'b0
) (
    input  addr_t     addr,
    output rom_word_t word
);
    generate
        if (MERGED_ROM) begin : g_merged
            localparam rom_image_t IMAGE = build_image(TABLES);
            assign word = IMAGE[addr];
        end else begin : g_split
            logic [WORD_W-1:0] bits;
            for (genvar k = 0; k < WORD_W; k++) begin : g_bit
                rmf_rom_bit #(.CONTENT(TABLES[k])) i_rom (
                    .addr (addr),
                    .data (bits[k])
                );
            end
            assign word = rom_word_t'(bits);
        end
    endgenerate
endmodule

// File: rtl/rmf_state_reg.sv
module rmf_state_reg
    import rmf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  state_t d,
    output state_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (q == $past(q)));
endmodule

// File: rtl/rom_mealy_fsm.sv
module rom_mealy_fsm
    import rmf_pkg::*;
#(
    parameter table_t NS1_TABLE  = 8'h72,
    parameter table_t NS0_TABLE  = 8'h9E,
    parameter table_t OUT1_TABLE = 8'h57,
    parameter table_t OUT0_TABLE = 8'hD8,
    parameter bit     MERGED_ROM = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       din,
    output logic [1:0] state_q,
    output logic [1:0] dout
);
    localparam table_set_t TABLES = {NS1_TABLE, NS0_TABLE, OUT1_TABLE, OUT0_TABLE};

    addr_t     addr;
    rom_word_t word;
    state_t    cur;

    assign addr = make_addr(cur, din);

    rmf_lookup #(.TABLES(TABLES), .MERGED_ROM(MERGED_ROM)) i_lookup (
        .addr (addr),
        .word (word)
    );

    rmf_state_reg i_state (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d   (word.nxt),
        .q   (cur)
    );

    assign state_q = cur;
    assign dout    = word.out;

    // R3
    load_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (state_q == $past(word.nxt)));

    // R2
    out_src_chk: assert property (@(posedge clk) disable iff (rst)
        dout == {OUT1_TABLE[{state_q, din}], OUT0_TABLE[{state_q, din}]});

    // R2
    nxt_src_chk: assert property (@(posedge clk) disable iff (rst)
        word.nxt == {NS1_TABLE[{state_q, din}], NS0_TABLE[{state_q, din}]});
endmodule

// File: tb/test_rom_mealy_fsm.sv
module test_rom_mealy_fsm;
    localparam logic [7:0] A_NS1 = 8'hA5, A_NS0 = 8'h3C, A_O1 = 8'hF0, A_O0 = 8'h0F;

    logic clk = 1'b0;
    logic rst = 1'b1, en = 1'b0, din = 1'b0;
    logic [1:0] st_n, st_w, st_a, do_n, do_w, do_a;
    logic [1:0] exp_s, exp_a;
    bit   valid = 1'b0;
    int   n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    rom_mealy_fsm i_rom_mealy_fsm (
        .clk(clk), .rst(rst), .en(en), .din(din), .state_q(st_n), .dout(do_n));
    rom_mealy_fsm #(.MERGED_ROM(1'b1)) i_rom_mealy_fsm_wide (
        .clk(clk), .rst(rst), .en(en), .din(din), .state_q(st_w), .dout(do_w));
    rom_mealy_fsm #(.NS1_TABLE(A_NS1), .NS0_TABLE(A_NS0), .OUT1_TABLE(A_O1),
                    .OUT0_TABLE(A_O0)) i_rom_mealy_fsm_alt (
        .clk(clk), .rst(rst), .en(en), .din(din), .state_q(st_a), .dout(do_a));

    function automatic logic [3:0] ref_default(input logic [1:0] s, input logic d);
        case ({s, d})
            3'b000: return 4'b00_10;
            3'b001: return 4'b11_10;
            3'b010: return 4'b01_10;
            3'b011: return 4'b01_01;
            3'b100: return 4'b11_11;
            3'b101: return 4'b10_00;
            3'b110: return 4'b10_11;
            default: return 4'b01_01;
        endcase
    endfunction

    function automatic logic [3:0] ref_alt(input logic [1:0] s, input logic d);
        logic [2:0] a = {s, d};
        return {A_NS1[a], A_NS0[a], A_O1[a], A_O0[a]};
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic d, input bit midflip);
        @(negedge clk);
        rst = r; en = e; din = d;
        #1;
        if (valid) begin
            check("R4", do_n, ref_default(exp_s, d)[1:0]);
            check("R9", do_w, do_n);
            check("R8", do_a, ref_alt(exp_a, d)[1:0]);
            if (midflip) begin
                din = ~d;
                #1;
                check("R5", do_n, ref_default(exp_s, ~d)[1:0]);
                din = d;
                #1;
            end
        end
        @(posedge clk);
        if (r) begin
            exp_s = 2'b00; exp_a = 2'b00; valid = 1'b1;
        end else if (e) begin
            exp_s = ref_default(exp_s, d)[3:2];
            exp_a = ref_alt(exp_a, d)[3:2];
        end
        #1;
        check(r ? "R1" : (e ? "R3" : "R6"), st_n, exp_s);
        check("R9", st_w, st_n);
        check(r ? "R7" : "R8", st_a, exp_a);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        exp_s = 2'b00; exp_a = 2'b00;
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        // R2 R3: cover all addresses; state 01 is left by reset
        step(0, 1, 0, 1);   // addr 000
        step(0, 1, 1, 1);   // addr 001 -> 11
        step(0, 1, 1, 0);   // addr 111 -> 01
        step(0, 1, 0, 1);   // addr 010
        step(0, 1, 1, 0);   // addr 011
        step(1, 1, 1, 0);   // R7: reset with enable high
        step(0, 1, 1, 0);   // -> 11
        step(0, 1, 0, 1);   // addr 110 -> 10
        step(0, 1, 1, 0);   // addr 101 -> 10
        step(0, 0, 0, 0);   // R6: hold at 10
        step(0, 0, 1, 1);
        step(0, 1, 0, 0);   // addr 100 -> 11
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 23) == 0, ($urandom % 4) != 0, $urandom % 2, ($urandom % 8) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule